// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one translation entry from a flat table in memory. A requester presents the virtual address together with the kind of access it wants to make: read, write or execute. The walker forms the entry's address from a table base register and the virtual page number, then reads that word over a simple request/acknowledge memory port. It judges the entry's valid and permission bits, and answers with either a physical address or a fault carrying a cause code.

On a successful walk, the walker keeps the entry's usage bookkeeping current before it answers. The referenced flag is set on any use, and the dirty flag is set on a write. The updated word is written back with one memory write, and only when one of those flags actually changes. The table base register can be reloaded at any time, for example on a context switch. Only one walk is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: For an accepted request, the walker issues exactly one memory read whose address equals the base register value plus the virtual page number (vaddr[31:12]) multiplied by 4, computed modulo 2^32.
- R2: A walk that does not fault responds with rsp_fault=0, rsp_cause=00 and rsp_paddr = {entry[31:12], vaddr[11:0]}.
- R3: An entry with its valid bit (bit 0) clear produces rsp_fault=1 with cause 01, and no memory write is issued for that walk.
- R4: The access kind is encoded as 00 read, 01 write, 10 execute and 11 reserved. A walk on a valid entry whose permission bit for the kind is clear (bit 1 read, bit 2 write, bit 3 execute), or whose kind is reserved, produces rsp_fault=1 with cause 10 and no memory write.
- R5: On a walk that does not fault, if the referenced bit (bit 4) is clear, the walker writes the entry back to the same address with bit 4 set and all other bits unchanged except as R6 says, before responding. If no flag needs to change, no write is issued.
- R6: On a write access that does not fault, the written-back entry has the dirty bit (bit 5) set. A write access to an entry that already has both bit 4 and bit 5 set issues no write.
- R7: A base reload (base_load=1) takes effect at the clock edge. A request accepted on that same edge still uses the previous base value, and every request accepted after that edge uses the new value.
- R8: req_ready is high only while no walk is in progress. rsp_valid is a single-cycle pulse per accepted request. mem_req, mem_we and mem_addr are held stable until mem_ack.
- R9: After reset, req_ready=1, mem_req=0, rsp_valid=0 and the base register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Reload the table base register |
| base_val | input | 32 | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when req_valid is high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for the entry write-back, 0 for the entry fetch |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated entry for the write-back |
| mem_ack | input | 1 | Memory acknowledge; for a read, mem_rdata is valid with it |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 2 | 00 none, 01 not valid, 10 permission violation |
| rsp_paddr | output | 32 | Physical address when no fault |

## Verification
Two things can happen in the same cycle: a base register reload and the acceptance of a new request. The bench provokes this by raising base_load and req_valid on the same edge. It then judges the result by the address of the entry fetch, which must come from the old base, and then by the next walk, which must fetch from the new base. A second collision is inside a single walk, where the referenced and dirty updates fall due together. Random write accesses to entries with both flags clear confirm that they merge into one write-back carrying both bits.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int PTE_LOG2  = 2;
    localparam int VPN_W     = ADDR_W - PAGE_BITS;
    localparam int PPN_W     = ADDR_W - PAGE_BITS;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_INVALID = 2'b01,
        CAUSE_PERM    = 2'b10
    } fault_cause_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [5:0]       spare;
        logic             dirty;
        logic             refd;
        logic             perm_x;
        logic             perm_w;
        logic             perm_r;
        logic             valid;
    } pte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WBACK,
        ST_REPLY
    } walk_st_e;

    function automatic logic kind_allowed(input pte_t e, input acc_kind_e k);
        logic ok;
        case (k)
            ACC_READ:  ok = e.perm_r;
            ACC_WRITE: ok = e.perm_w;
            ACC_EXEC:  ok = e.perm_x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] ent_addr
);
    localparam int SCALED_W = VPN_W + PTE_LOG2;

    logic [ADDR_W-1:0] base_q;
    logic [SCALED_W-1:0] vpn_scaled;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RST;
        end else if (base_load) begin
            base_q <= base_val;
        end
    end

    assign vpn_scaled = {vpn, {PTE_LOG2{1'b0}}};
    assign ent_addr   = base_q + ADDR_W'(vpn_scaled);

endmodule

// File: rtl/xw_judge.sv
module xw_judge
    import xw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  acc_kind_e         kind,
    output logic              fault,
    output fault_cause_e      cause,
    output logic              need_wb,
    output logic [ADDR_W-1:0] upd_entry
);
    pte_t e;
    pte_t upd;

    always_comb begin
        e   = pte_t'(entry);
        upd = e;
        upd.refd = 1'b1;
        if (kind == ACC_WRITE) begin
            upd.dirty = 1'b1;
        end
        if (!e.valid) begin
            fault = 1'b1;
            cause = CAUSE_INVALID;
        end else if (!kind_allowed(e, kind)) begin
            fault = 1'b1;
            cause = CAUSE_PERM;
        end else begin
            fault = 1'b0;
            cause = CAUSE_NONE;
        end
        need_wb   = !fault && (upd != e);
        upd_entry = ADDR_W'(upd);
    end

endmodule

// File: rtl/xw_seq.sv
module xw_seq
    import xw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PAGE_BITS-1:0] req_offset,
    input  acc_kind_e            req_kind,
    input  logic [ADDR_W-1:0]    ent_addr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [ADDR_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [ADDR_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    entry_q,
    output acc_kind_e            kind_q,
    input  logic                 j_fault,
    input  fault_cause_e         j_cause,
    input  logic                 j_need_wb,
    input  logic [ADDR_W-1:0]    j_upd,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [1:0]           rsp_cause,
    output logic [ADDR_W-1:0]    rsp_paddr
);
    walk_st_e              st;
    logic [ADDR_W-1:0]     addr_q;
    logic [PAGE_BITS-1:0]  off_q;
    logic [ADDR_W-1:0]     wb_q;
    logic                  fault_q;
    fault_cause_e          cause_q;
    logic [ADDR_W-1:0]     paddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            off_q   <= '0;
            kind_q  <= ACC_READ;
            entry_q <= '0;
            wb_q    <= '0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= ent_addr;
                        off_q  <= req_offset;
                        kind_q <= req_kind;
                        st     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        entry_q <= mem_rdata;
                        st      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    fault_q <= j_fault;
                    cause_q <= j_cause;
                    paddr_q <= j_fault ? '0 : {entry_q[ADDR_W-1:PAGE_BITS], off_q};
                    wb_q    <= j_upd;
                    st      <= j_need_wb ? ST_WBACK : ST_REPLY;
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        st <= ST_REPLY;
                    end
                end
                ST_REPLY: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign mem_req   = (st == ST_FETCH) || (st == ST_WBACK);
    assign mem_we    = (st == ST_WBACK);
    assign mem_addr  = addr_q;
    assign mem_wdata = wb_q;
    assign rsp_valid = (st == ST_REPLY);
    assign rsp_fault = rsp_valid && fault_q;
    assign rsp_cause = rsp_valid ? cause_q : CAUSE_NONE;
    assign rsp_paddr = rsp_valid ? paddr_q : '0;

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
#(
    parameter logic [31:0] BASE_RST = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        base_load,
    input  logic [31:0] base_val,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [1:0]  rsp_cause,
    output logic [31:0] rsp_paddr
);
    logic [ADDR_W-1:0] ent_addr;
    logic [ADDR_W-1:0] entry_q;
    acc_kind_e         kind_q;
    logic              j_fault;
    fault_cause_e      j_cause;
    logic              j_need_wb;
    logic [ADDR_W-1:0] j_upd;

    xw_addr_gen #(.BASE_RST(BASE_RST)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .base_load (base_load),
        .base_val  (base_val),
        .vpn       (req_vaddr[ADDR_W-1:PAGE_BITS]),
        .ent_addr  (ent_addr)
    );

    xw_judge u_judge (
        .entry     (entry_q),
        .kind      (kind_q),
        .fault     (j_fault),
        .cause     (j_cause),
        .need_wb   (j_need_wb),
        .upd_entry (j_upd)
    );

    xw_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_offset (req_vaddr[PAGE_BITS-1:0]),
        .req_kind   (acc_kind_e'(req_kind)),
        .ent_addr   (ent_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .entry_q    (entry_q),
        .kind_q     (kind_q),
        .j_fault    (j_fault),
        .j_cause    (j_cause),
        .j_need_wb  (j_need_wb),
        .j_upd      (j_upd),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_cause  (rsp_cause),
        .rsp_paddr  (rsp_paddr)
    );

endmodule

// File: rtl/xw_chk.sv
module xw_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_paddr
);
    logic [11:0] off_seen;
    logic [1:0]  kind_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_seen  <= '0;
            kind_seen <= '0;
        end else if (req_valid && req_ready) begin
            off_seen  <= req_vaddr[11:0];
            kind_seen <= req_kind;
        end
    end

    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00); // R1

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == off_seen); // R2

    AST_WB_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[0]); // R3

    AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00)) && rsp_cause != 2'b11); // R4

    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[4]); // R5

    AST_WB_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && kind_seen == 2'b01 |-> mem_wdata[5]); // R6

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready); // R8

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8

    AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req && !rsp_valid); // R9

endmodule

bind xlat_walker xw_chk u_xw_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_kind  (req_kind),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        base_load;
    logic [31:0] base_val;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;

    int checks   = 0;
    int failures = 0;
    logic done = 1'b0;

    logic [31:0] mem [256];
    int          wr_cnt;
    int          rd_cnt;
    logic [31:0] rd_addr_seen;
    logic [31:0] wr_addr_seen;
    int          wait_cnt;
    logic [31:0] cur_base;

    always #10 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk       (clk),
        .rst       (rst),
        .base_load (base_load),
        .base_val  (base_val),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vaddr (req_vaddr),
        .req_kind  (req_kind),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wait_cnt  <= 0;
            wr_cnt    <= 0;
            rd_cnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    wr_addr_seen       <= mem_addr;
                    wr_cnt             <= wr_cnt + 1;
                end else begin
                    mem_rdata    <= mem[mem_addr[9:2]];
                    rd_addr_seen <= mem_addr;
                    rd_cnt       <= rd_cnt + 1;
                end
                wait_cnt <= $urandom_range(0, 2);
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic perm_of(input logic [31:0] e, input logic [1:0] k);
        case (k)
            2'b00:   return e[1];
            2'b01:   return e[2];
            2'b10:   return e[3];
            default: return 1'b0;
        endcase
    endfunction

    // expected response and expected memory image after one walk
    function automatic void model(input logic [31:0] e, input logic [31:0] va,
                                  input logic [1:0] k, output logic f,
                                  output logic [1:0] c, output logic [31:0] pa,
                                  output logic [31:0] ne, output logic wb);
        f  = 1'b0; c = 2'b00; pa = '0; ne = e; wb = 1'b0;
        if (!e[0]) begin
            f = 1'b1; c = 2'b01;
        end else if (!perm_of(e, k)) begin
            f = 1'b1; c = 2'b10;
        end else begin
            pa = {e[31:12], va[11:0]};
            ne = e | 32'h10 | ((k == 2'b01) ? 32'h20 : 32'h0);
            wb = (ne != e);
        end
    endfunction

    task automatic walk(input logic [31:0] va, input logic [1:0] k,
                        input logic [31:0] entry, input logic ld,
                        input logic [31:0] nb);
        logic [31:0] ea;
        logic f, wb;
        logic [1:0] c;
        logic [31:0] pa, ne;
        int w0, r0, n;
        ea = cur_base + {va[31:12], 2'b00};
        mem[ea[9:2]] = entry;
        model(entry, va, k, f, c, pa, ne, wb);
        w0 = wr_cnt;
        r0 = rd_cnt;
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = k;
        base_load = ld;
        base_val  = nb;
        @(negedge clk);
        req_valid = 1'b0;
        base_load = 1'b0;
        if (ld) cur_base = nb;
        check(!req_ready, "R8", "req_ready during walk", {31'd0, req_ready}, 32'd0);
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R8", "response arrived", {31'd0, rsp_valid}, 32'd1);
        check(rd_cnt - r0 == 1, "R1", "one entry read", rd_cnt - r0, 32'd1);
        check(rd_addr_seen == ea, "R1 R7", "entry address", rd_addr_seen, ea);
        check(rsp_fault == f, f ? (c == 2'b01 ? "R3" : "R4") : "R2",
              "fault flag", {31'd0, rsp_fault}, {31'd0, f});
        check(rsp_cause == c, f ? (c == 2'b01 ? "R3" : "R4") : "R2",
              "cause", {30'd0, rsp_cause}, {30'd0, c});
        if (!f) check(rsp_paddr == pa, "R2", "paddr", rsp_paddr, pa);
        check(wr_cnt - w0 == (wb ? 1 : 0), (k == 2'b01) ? "R6" : "R5",
              "write-back count", wr_cnt - w0, wb ? 32'd1 : 32'd0);
        check(mem[ea[9:2]] == ne, (k == 2'b01) ? "R6" : "R5",
              "entry after walk", mem[ea[9:2]], ne);
        if (wb) check(wr_addr_seen == ea, "R5", "write-back address", wr_addr_seen, ea);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R8", "single-cycle response",
              {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] e, va, nb;
        logic [1:0] k;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        rst = 1'b1; base_load = 1'b0; base_val = '0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        cur_base = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_req && !rsp_valid, "R9", "reset outputs",
              {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);
        // R9: base is zero after reset: vpn 3 fetches address 12
        walk(32'h0000_3ABC, 2'b00, 32'h12345_003, 1'b0, '0);
        // R5: referenced already set, read: no write
        walk(32'h0000_3ABC, 2'b00, 32'h12345_013, 1'b0, '0);
        // R3: invalid entry with every other bit set
        walk(32'h0001_0FFF, 2'b01, 32'hFFFFF_FFE, 1'b0, '0);
        // R4: each kind refused, reserved kind refused
        walk(32'h0002_0004, 2'b01, 32'h00AAA_00B, 1'b0, '0);
        walk(32'h0002_0008, 2'b10, 32'h00AAA_007, 1'b0, '0);
        walk(32'h0002_000C, 2'b00, 32'h00AAA_00D, 1'b0, '0);
        walk(32'h0002_0010, 2'b11, 32'h00AAA_00F, 1'b0, '0);
        // R6: first write sets ref and dirty in one write-back
        walk(32'hABCD_E123, 2'b01, 32'h54321_005, 1'b0, '0);
        // R6: ref set, dirty clear -> write for dirty only
        walk(32'hABCD_E123, 2'b01, 32'h54321_015, 1'b0, '0);
        // R6: both set -> no write
        walk(32'hABCD_E123, 2'b01, 32'h54321_035, 1'b0, '0);
        // R7: reload in the same cycle as acceptance uses old base
        walk(32'h0000_5000, 2'b10, 32'h0BEEF_009, 1'b1, 32'h0000_0200);
        walk(32'h0000_5000, 2'b10, 32'h0BEEF_009, 1'b0, '0);
        // R1: base plus vpn wraps past 2^32
        walk(32'hFFFF_F777, 2'b00, 32'h7777_7003, 1'b1, 32'hFFFF_FF00);
        walk(32'hFFFF_F777, 2'b00, 32'h7777_7003, 1'b0, '0);
        for (int i = 0; i < 150; i++) begin
            va = $urandom;
            k  = 2'($urandom_range(0, 3));
            e  = $urandom;
            if ($urandom_range(0, 9) < 8) e[0] = 1'b1;
            nb = {$urandom, 2'b00};
            walk(va, k, e, ($urandom_range(0, 7) == 0), nb);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule